// File: doc/BRIEF.md
# Multi-Bank Receive Endpoint Buffer Controller

This block holds the receive side of one device-side OUT endpoint. Packet storage is a ring of one to three banks. A byte-strobe receive port writes into the bank the bus side currently targets. A firmware-facing port reads bytes out of the bank the processor currently holds, then hands that bank back to the ring. For each bank the block keeps a full/empty state and the byte count captured at end of packet.

Two flags tell firmware that a packet is waiting. The first is a received-packet flag, which drives the interrupt through an enable. The second is an ownership flag, and clearing it returns the bank. The two flags are cleared in a fixed order. Returning a bank moves the processor pointer to the next bank in the ring and reloads both flags from that bank's state.

The bus side does not overwrite a bank that is still full. It drops the packet and pulses a NAK indication instead. A synchronous endpoint reset returns the whole block to its empty state.

Top module: `usb_out_bank_ctrl`

## Requirements
- R1: When an accepted packet completes into the bank the processor pointer selects, the received-packet flag and the ownership flag both become 1 at the same clock edge.
- R2: The interrupt output is 1 exactly when the received-packet flag is 1 and the interrupt enable input is 1.
- R3: A pulse on the flag-clear input clears the received-packet flag. It leaves the ownership flag, the data-available bit, the byte count, the read data and every bank unchanged.
- R4: A bank-return request made while the ownership flag is 1 and the received-packet flag is 0 empties the current bank. It also moves the processor pointer to the next bank, wrapping modulo the number of banks. A request made while the ownership flag is 0 is ignored.
- R5: After a bank return, both flags equal the full state of the newly selected bank, including a packet that completes into that bank in the same cycle.
- R6: The data-available bit is 1 while the ownership flag is 1 and the read index is below the bank's byte count. The read data port presents the bank's bytes in arrival order, and a read strobe advances to the next byte. A read strobe with data-available at 0 has no effect.
- R7: A bank-return request made while both flags are 1 sets a sticky ordering-error bit and changes nothing else.
- R8: The bus-side pointer advances modulo the number of banks after each accepted packet. A packet whose target bank is full when its first byte (or its end marker, for an empty packet) arrives is discarded. In that case the NAK output is 1 for one cycle, the cycle after the end marker, and the full bank keeps its contents.
- R9: The end marker latches the number of stored bytes as the bank's count. A byte carried in the same cycle as the end marker is counted. Bytes beyond the bank capacity are dropped, so the count saturates at the capacity. A packet of zero length still fills a bank, with count 0.
- R10: One cycle of endpoint reset empties all banks, returns both pointers to bank 0 and clears both flags, the ordering-error bit and the NAK output.
- R11: After power-on reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ep_reset | input | 1 | Synchronous endpoint reset |
| rx_valid | input | 1 | Receive byte strobe |
| rx_data | input | DW | Receive byte |
| rx_eop | input | 1 | End-of-packet marker; may carry a final byte with rx_valid |
| rx_nak | output | 1 | One-cycle pulse after the end marker of a discarded packet |
| irq_en | input | 1 | Interrupt enable for the received-packet flag |
| cpu_rd | input | 1 | Read strobe: advance to the next byte |
| cpu_ack | input | 1 | Clear the received-packet flag |
| cpu_release | input | 1 | Clear the ownership flag and return the bank |
| cpu_rd_data | output | DW | Byte at the read index, 0 when no data is available |
| cpu_byte_count | output | CW | Byte count of the owned bank, 0 when none is owned |
| pkt_flag | output | 1 | Received-packet flag |
| own_flag | output | 1 | Ownership flag |
| data_avail | output | 1 | Unread bytes remain in the owned bank |
| order_err | output | 1 | Sticky ordering-error bit |
| ep_irq | output | 1 | Endpoint interrupt |

## Verification
Most internal faults show at the ports within one or two operations. A wrong processor pointer or a stale full bit makes the reloaded flags disagree with the model right after the next bank return. It also surfaces a byte count that belongs to another bank. A bad read index or a misrouted write shows up on the first read strobe as a wrong byte or as a data-available edge in the wrong place. A wrong bus-side pointer is exposed by a NAK that appears or goes missing on the packet after the ring is filled. The endpoint reset check then shows whether both pointers really returned to bank 0.

// File: rtl/oeb_pkg.sv
package oeb_pkg;

  // Ring successor of a bank index for a ring of n banks.
  function automatic int unsigned oeb_wrap_inc(int unsigned p, int unsigned n);
    return (p + 1 >= n) ? 0 : p + 1;
  endfunction

endpackage

// File: rtl/oeb_bank_store.sv
module oeb_bank_store #(
  parameter int NB = 3,
  parameter int BB = 16,
  parameter int DW = 8,
  localparam int PW = (NB < 2) ? 1 : $clog2(NB),
  localparam int NS = 1 << PW,
  localparam int AW = $clog2(BB),
  localparam int CW = $clog2(BB + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr_en,
  input  logic [PW-1:0] wr_bank,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          commit,
  input  logic [PW-1:0] commit_bank,
  input  logic [CW-1:0] commit_cnt,
  input  logic          free,
  input  logic [PW-1:0] free_bank,
  input  logic [PW-1:0] rd_bank,
  input  logic [AW-1:0] rd_addr,
  output logic [NS-1:0] full_vec,
  output logic [DW-1:0] rd_data,
  output logic [CW-1:0] rd_count
);

  logic [DW-1:0] bank_data [NS];
  logic [CW-1:0] bank_cnt  [NS];

  for (genvar b = 0; b < NS; b++) begin : g_bank
    if (b < NB) begin : g_real
      logic [DW-1:0] mem_q [BB];
      logic          full_q, full_d;
      logic [CW-1:0] cnt_q, cnt_d;
      logic          wr_hit, upd;

      assign wr_hit = wr_en && (wr_bank == PW'(b));
      assign upd    = clr || free || commit;

      always_ff @(posedge clk) begin
        if (wr_hit) mem_q[wr_addr] <= wr_data;
      end

      always_comb begin
        full_d = full_q;
        cnt_d  = cnt_q;
        if (clr) begin
          full_d = 1'b0;
          cnt_d  = '0;
        end else begin
          if (free && (free_bank == PW'(b))) full_d = 1'b0;
          if (commit && (commit_bank == PW'(b))) begin
            full_d = 1'b1;
            cnt_d  = commit_cnt;
          end
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          full_q <= 1'b0;
          cnt_q  <= '0;
        end else if (upd) begin
          full_q <= full_d;
          cnt_q  <= cnt_d;
        end
      end

      assign full_vec[b]  = full_q;
      assign bank_data[b] = mem_q[rd_addr];
      assign bank_cnt[b]  = cnt_q;
    end else begin : g_pad
      assign full_vec[b]  = 1'b0;
      assign bank_data[b] = '0;
      assign bank_cnt[b]  = '0;
    end
  end

  assign rd_data  = bank_data[rd_bank];
  assign rd_count = bank_cnt[rd_bank];

endmodule

// File: rtl/oeb_rx_fill.sv
module oeb_rx_fill
  import oeb_pkg::*;
#(
  parameter int NB = 3,
  parameter int BB = 16,
  parameter int DW = 8,
  localparam int PW = (NB < 2) ? 1 : $clog2(NB),
  localparam int NS = 1 << PW,
  localparam int AW = $clog2(BB),
  localparam int CW = $clog2(BB + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_eop,
  input  logic [NS-1:0] full_vec,
  output logic          wr_en,
  output logic [PW-1:0] wr_bank,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          commit,
  output logic [PW-1:0] commit_bank,
  output logic [CW-1:0] commit_cnt,
  output logic          rx_nak
);

  logic [PW-1:0] hw_ptr_q, hw_ptr_d;
  logic [CW-1:0] wr_idx_q, wr_idx_d;
  logic          in_pkt_q, in_pkt_d;
  logic          drop_q, drop_d;
  logic          nak_q, nak_d;
  logic          reject, stores, step;
  logic [CW-1:0] cnt_now;

  // The accept/reject decision is taken at the first beat of a packet.
  assign reject  = in_pkt_q ? drop_q : full_vec[hw_ptr_q];
  assign stores  = rx_valid && !reject && (wr_idx_q < CW'(BB));
  assign cnt_now = wr_idx_q + CW'(stores);
  assign step    = clr || rx_eop || rx_valid || nak_q;

  assign wr_en       = stores;
  assign wr_bank     = hw_ptr_q;
  assign wr_addr     = wr_idx_q[AW-1:0];
  assign wr_data     = rx_data;
  assign commit      = rx_eop && !reject && !clr;
  assign commit_bank = hw_ptr_q;
  assign commit_cnt  = cnt_now;
  assign rx_nak      = nak_q;

  always_comb begin
    hw_ptr_d = hw_ptr_q;
    wr_idx_d = wr_idx_q;
    in_pkt_d = in_pkt_q;
    drop_d   = drop_q;
    nak_d    = 1'b0;
    if (clr) begin
      hw_ptr_d = '0;
      wr_idx_d = '0;
      in_pkt_d = 1'b0;
      drop_d   = 1'b0;
    end else if (rx_eop) begin
      wr_idx_d = '0;
      in_pkt_d = 1'b0;
      drop_d   = 1'b0;
      nak_d    = reject;
      if (!reject) hw_ptr_d = PW'(oeb_wrap_inc(32'(hw_ptr_q), NB));
    end else if (rx_valid) begin
      in_pkt_d = 1'b1;
      drop_d   = reject;
      wr_idx_d = cnt_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hw_ptr_q <= '0;
      wr_idx_q <= '0;
      in_pkt_q <= 1'b0;
      drop_q   <= 1'b0;
      nak_q    <= 1'b0;
    end else if (step) begin
      hw_ptr_q <= hw_ptr_d;
      wr_idx_q <= wr_idx_d;
      in_pkt_q <= in_pkt_d;
      drop_q   <= drop_d;
      nak_q    <= nak_d;
    end
  end

endmodule

// File: rtl/oeb_cpu_port.sv
module oeb_cpu_port
  import oeb_pkg::*;
#(
  parameter int NB = 3,
  parameter int BB = 16,
  localparam int PW = (NB < 2) ? 1 : $clog2(NB),
  localparam int NS = 1 << PW,
  localparam int AW = $clog2(BB),
  localparam int CW = $clog2(BB + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          cpu_rd,
  input  logic          cpu_ack,
  input  logic          cpu_release,
  input  logic [NS-1:0] full_vec,
  input  logic          commit,
  input  logic [PW-1:0] commit_bank,
  input  logic [CW-1:0] rd_count,
  output logic [PW-1:0] cpu_ptr,
  output logic [AW-1:0] rd_addr,
  output logic          free,
  output logic [PW-1:0] free_bank,
  output logic          pkt_flag,
  output logic          own_flag,
  output logic          data_avail,
  output logic          order_err
);

  logic [PW-1:0] ptr_q, ptr_d, nxt;
  logic [CW-1:0] rd_idx_q, rd_idx_d;
  logic          pkt_q, pkt_d, own_q, own_d, err_q, err_d;
  logic          avail, rel_ok, rel_bad, nxt_full, fill_here, step;

  assign nxt       = PW'(oeb_wrap_inc(32'(ptr_q), NB));
  assign avail     = own_q && (rd_idx_q < rd_count);
  assign rel_ok    = cpu_release && own_q && !pkt_q && !clr;
  assign rel_bad   = cpu_release && own_q && pkt_q;
  assign fill_here = commit && (commit_bank == ptr_q);
  // With a single bank the successor is the bank being freed.
  assign nxt_full  = ((nxt != ptr_q) && full_vec[nxt]) ||
                     (commit && (commit_bank == nxt));
  assign step      = clr || cpu_rd || cpu_ack || cpu_release || commit;

  always_comb begin
    ptr_d    = ptr_q;
    rd_idx_d = rd_idx_q;
    pkt_d    = pkt_q;
    own_d    = own_q;
    err_d    = err_q;
    if (clr) begin
      ptr_d    = '0;
      rd_idx_d = '0;
      pkt_d    = 1'b0;
      own_d    = 1'b0;
      err_d    = 1'b0;
    end else begin
      if (cpu_rd && avail) rd_idx_d = rd_idx_q + CW'(1);
      if (cpu_ack) pkt_d = 1'b0;
      if (rel_bad) err_d = 1'b1;
      if (rel_ok) begin
        ptr_d    = nxt;
        rd_idx_d = '0;
        own_d    = nxt_full;
        pkt_d    = nxt_full;
      end else if (fill_here) begin
        own_d = 1'b1;
        pkt_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q    <= '0;
      rd_idx_q <= '0;
      pkt_q    <= 1'b0;
      own_q    <= 1'b0;
      err_q    <= 1'b0;
    end else if (step) begin
      ptr_q    <= ptr_d;
      rd_idx_q <= rd_idx_d;
      pkt_q    <= pkt_d;
      own_q    <= own_d;
      err_q    <= err_d;
    end
  end

  assign cpu_ptr    = ptr_q;
  assign rd_addr    = rd_idx_q[AW-1:0];
  assign free       = rel_ok;
  assign free_bank  = ptr_q;
  assign pkt_flag   = pkt_q;
  assign own_flag   = own_q;
  assign data_avail = avail;
  assign order_err  = err_q;

endmodule

// File: rtl/usb_out_bank_ctrl.sv
module usb_out_bank_ctrl #(
  parameter int NB = 3,
  parameter int BB = 16,
  parameter int DW = 8,
  localparam int PW = (NB < 2) ? 1 : $clog2(NB),
  localparam int NS = 1 << PW,
  localparam int AW = $clog2(BB),
  localparam int CW = $clog2(BB + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ep_reset,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_eop,
  output logic          rx_nak,
  input  logic          irq_en,
  input  logic          cpu_rd,
  input  logic          cpu_ack,
  input  logic          cpu_release,
  output logic [DW-1:0] cpu_rd_data,
  output logic [CW-1:0] cpu_byte_count,
  output logic          pkt_flag,
  output logic          own_flag,
  output logic          data_avail,
  output logic          order_err,
  output logic          ep_irq
);

  logic [1:0]    rst_sync_q;
  logic          rst_int_n;
  logic          wr_en, commit, free;
  logic [PW-1:0] wr_bank, commit_bank, free_bank, cpu_ptr;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [DW-1:0] wr_data, store_rd;
  logic [CW-1:0] commit_cnt, rd_count;
  logic [NS-1:0] full_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  oeb_bank_store #(.NB(NB), .BB(BB), .DW(DW)) i_store (
    .clk(clk), .rst_n(rst_int_n), .clr(ep_reset),
    .wr_en(wr_en), .wr_bank(wr_bank), .wr_addr(wr_addr), .wr_data(wr_data),
    .commit(commit), .commit_bank(commit_bank), .commit_cnt(commit_cnt),
    .free(free), .free_bank(free_bank),
    .rd_bank(cpu_ptr), .rd_addr(rd_addr),
    .full_vec(full_vec), .rd_data(store_rd), .rd_count(rd_count)
  );

  oeb_rx_fill #(.NB(NB), .BB(BB), .DW(DW)) i_fill (
    .clk(clk), .rst_n(rst_int_n), .clr(ep_reset),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_eop(rx_eop),
    .full_vec(full_vec),
    .wr_en(wr_en), .wr_bank(wr_bank), .wr_addr(wr_addr), .wr_data(wr_data),
    .commit(commit), .commit_bank(commit_bank), .commit_cnt(commit_cnt),
    .rx_nak(rx_nak)
  );

  oeb_cpu_port #(.NB(NB), .BB(BB)) i_cpu (
    .clk(clk), .rst_n(rst_int_n), .clr(ep_reset),
    .cpu_rd(cpu_rd), .cpu_ack(cpu_ack), .cpu_release(cpu_release),
    .full_vec(full_vec), .commit(commit), .commit_bank(commit_bank),
    .rd_count(rd_count),
    .cpu_ptr(cpu_ptr), .rd_addr(rd_addr), .free(free), .free_bank(free_bank),
    .pkt_flag(pkt_flag), .own_flag(own_flag), .data_avail(data_avail),
    .order_err(order_err)
  );

  assign cpu_rd_data    = data_avail ? store_rd : '0;
  assign cpu_byte_count = own_flag ? rd_count : '0;
  assign ep_irq         = pkt_flag && irq_en;

endmodule

// File: rtl/oeb_checker.sv
module oeb_checker (
  input logic clk,
  input logic rst_n,
  input logic ep_reset,
  input logic rx_eop,
  input logic rx_nak,
  input logic irq_en,
  input logic cpu_ack,
  input logic cpu_release,
  input logic pkt_flag,
  input logic own_flag,
  input logic data_avail,
  input logic order_err,
  input logic ep_irq
);

  // R1 / R5: both flags rise together, and the packet flag never stands alone
  a_r1_pkt_needs_own: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_flag |-> own_flag);

  a_r1_own_rises_with_pkt: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(own_flag) |-> pkt_flag);

  // R2
  a_r2_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    ep_irq |-> (irq_en && own_flag));

  // R3
  a_r3_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ack && !rx_eop && !ep_reset) |=> !pkt_flag);

  // R6
  a_r6_avail_needs_own: assert property (@(posedge clk) disable iff (!rst_n)
    data_avail |-> own_flag);

  // R7
  a_r7_bad_release_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_release && own_flag && pkt_flag && !ep_reset) |=> (order_err && own_flag));

  // R8
  a_r8_nak_after_eop: assert property (@(posedge clk) disable iff (!rst_n)
    rx_nak |-> $past(rx_eop));

  // R10
  a_r10_ep_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ep_reset |=> (!own_flag && !pkt_flag && !data_avail && !order_err && !rx_nak));

endmodule

bind usb_out_bank_ctrl oeb_checker i_oeb_checker (
  .clk(clk), .rst_n(rst_n), .ep_reset(ep_reset), .rx_eop(rx_eop),
  .rx_nak(rx_nak), .irq_en(irq_en), .cpu_ack(cpu_ack),
  .cpu_release(cpu_release), .pkt_flag(pkt_flag), .own_flag(own_flag),
  .data_avail(data_avail), .order_err(order_err), .ep_irq(ep_irq)
);

// File: tb/test_usb_out_bank_ctrl.sv
`timescale 1ns/1ps
module test_usb_out_bank_ctrl;

  localparam int NB = 3;
  localparam int BB = 8;
  localparam int CW = $clog2(BB + 1);

  logic          clk = 1'b0;
  logic          rst_n, ep_reset, rx_valid, rx_eop, irq_en;
  logic          cpu_rd, cpu_ack, cpu_release;
  logic [7:0]    rx_data, cpu_rd_data;
  logic [CW-1:0] cpu_byte_count;
  logic          rx_nak, pkt_flag, own_flag, data_avail, order_err, ep_irq;

  always #2 clk = ~clk;

  usb_out_bank_ctrl #(.NB(NB), .BB(BB), .DW(8)) i_usb_out_bank_ctrl (
    .clk(clk), .rst_n(rst_n), .ep_reset(ep_reset),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_eop(rx_eop), .rx_nak(rx_nak),
    .irq_en(irq_en), .cpu_rd(cpu_rd), .cpu_ack(cpu_ack),
    .cpu_release(cpu_release), .cpu_rd_data(cpu_rd_data),
    .cpu_byte_count(cpu_byte_count), .pkt_flag(pkt_flag), .own_flag(own_flag),
    .data_avail(data_avail), .order_err(order_err), .ep_irq(ep_irq)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // reference model
  int m_full [NB];
  int m_cnt  [NB];
  int m_data [NB][BB];
  int m_hw, m_cpu, m_rd, m_pkt, m_own, m_err;

  function automatic int exp_avail();
    return (m_own != 0 && m_rd < m_cnt[m_cpu]) ? 1 : 0;
  endfunction

  function automatic int exp_count();
    return (m_own != 0) ? m_cnt[m_cpu] : 0;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk({tag, " pkt_flag"}, int'(pkt_flag), m_pkt);
    chk({tag, " own_flag"}, int'(own_flag), m_own);
    chk({tag, " order_err"}, int'(order_err), m_err);
    chk("R2 ep_irq", int'(ep_irq), (m_pkt != 0 && irq_en) ? 1 : 0);
    chk({tag, " data_avail"}, int'(data_avail), exp_avail());
    chk({tag, " byte_count"}, int'(cpu_byte_count), exp_count());
    if (exp_avail() != 0)
      chk({tag, " rd_data"}, int'(cpu_rd_data), m_data[m_cpu][m_rd]);
  endtask

  task automatic model_clear();
    for (int b = 0; b < NB; b++) begin
      m_full[b] = 0;
      m_cnt[b]  = 0;
    end
    m_hw = 0; m_cpu = 0; m_rd = 0; m_pkt = 0; m_own = 0; m_err = 0;
  endtask

  task automatic send_pkt(int len);
    int vals [BB+4];
    int rej, keep;
    rej = m_full[m_hw];
    for (int i = 0; i < len; i++) begin
      vals[i] = $urandom_range(0, 255);
      @(negedge clk);
      rx_valid = 1'b1;
      rx_data  = 8'(vals[i]);
      rx_eop   = (i == len - 1);
    end
    if (len == 0) begin
      @(negedge clk);
      rx_eop = 1'b1;
    end
    @(negedge clk);
    rx_valid = 1'b0;
    rx_eop   = 1'b0;
    chk("R8 rx_nak", int'(rx_nak), rej);
    if (rej == 0) begin
      keep = (len > BB) ? BB : len;
      for (int i = 0; i < keep; i++) m_data[m_hw][i] = vals[i];
      m_cnt[m_hw]  = keep;
      m_full[m_hw] = 1;
      if (m_hw == m_cpu) begin
        m_pkt = 1;
        m_own = 1;
      end
      m_hw = (m_hw + 1) % NB;
    end
    check_all("R1 R9");
  endtask

  task automatic do_read();
    @(negedge clk);
    cpu_rd = 1'b1;
    @(negedge clk);
    cpu_rd = 1'b0;
    if (exp_avail() != 0) m_rd++;
    check_all("R6");
  endtask

  task automatic do_ack();
    @(negedge clk);
    cpu_ack = 1'b1;
    @(negedge clk);
    cpu_ack = 1'b0;
    m_pkt = 0;
    check_all("R3");
  endtask

  task automatic do_release();
    @(negedge clk);
    cpu_release = 1'b1;
    @(negedge clk);
    cpu_release = 1'b0;
    if (m_own != 0) begin
      if (m_pkt != 0) m_err = 1;
      else begin
        m_full[m_cpu] = 0;
        m_cpu = (m_cpu + 1) % NB;
        m_rd  = 0;
        m_own = m_full[m_cpu];
        m_pkt = m_own;
      end
    end
    check_all("R4 R5 R7");
  endtask

  task automatic do_ep_reset();
    @(negedge clk);
    ep_reset = 1'b1;
    @(negedge clk);
    ep_reset = 1'b0;
    model_clear();
    check_all("R10");
    chk("R10 rx_nak", int'(rx_nak), 0);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0b17));
    rst_n = 1'b0; ep_reset = 1'b0; rx_valid = 1'b0; rx_eop = 1'b0;
    rx_data = 8'h00; irq_en = 1'b0; cpu_rd = 1'b0; cpu_ack = 1'b0;
    cpu_release = 1'b0;
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11: reset state
    check_all("R11");
    chk("R11 rx_nak", int'(rx_nak), 0);
    chk("R11 rd_data", int'(cpu_rd_data), 0);

    // R9: zero length packet, then R3 ack, R4 return
    irq_en = 1'b1;
    send_pkt(0);
    do_read();                     // R6: strobe with nothing to read
    do_ack();
    do_release();

    // R9: overflow saturates, R6 read to the end
    send_pkt(BB + 3);
    for (int i = 0; i < BB + 1; i++) do_read();

    // R7: return with packet flag still set
    do_release();
    do_release();
    do_ack();
    do_release();

    // R8: fill the ring, then one more is refused
    for (int i = 0; i < NB + 1; i++) send_pkt(1 + i);
    // R2: enable toggling while a packet waits
    @(negedge clk); irq_en = 1'b0;
    @(negedge clk); check_all("R2");
    @(negedge clk); irq_en = 1'b1;
    @(negedge clk); check_all("R2");

    // R10: endpoint reset mid-traffic, pointers back to bank 0
    do_ep_reset();
    send_pkt(2);
    do_read();

    // mixed random traffic
    for (int k = 0; k < 1500; k++) begin
      int op;
      op = $urandom_range(0, 99);
      if (op < 30)      send_pkt($urandom_range(0, BB + 2));
      else if (op < 60) do_read();
      else if (op < 75) do_ack();
      else if (op < 92) do_release();
      else if (op < 97) begin
        @(negedge clk);
        irq_en = ~irq_en;
        @(negedge clk);
        check_all("R2");
      end else do_ep_reset();
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule